// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that finishes each instruction within one clock period. It fetches a word from its private instruction store at the current program counter, decodes it with a fixed controller, reads two operands from a 32-entry register file, and runs them through a small adder/subtractor/OR unit. It then either writes a result back or accesses its private data store. The next program counter is also chosen in that same period. Only seven operations are understood: register add, register subtract, OR with an immediate, word load, word store, branch on equal and absolute jump. Every other encoding passes through as a no-op that only advances the counter.

Both stores are filled through a simple load port. This is normally done while the core is held in reset. A debug port shows the program counter of the instruction now executing, together with the register write that instruction will commit at the next rising clock edge. The reset input is asynchronous and active low. Its release reaches the core through a two-stage synchronizer, so the first instruction runs in the second full cycle after release.

Top module: `scp_core`

## Requirements
- R1: While rst_n is low, dbg_pc is 0 and dbg_wr_en is 0. After release, the first instruction executed is the word at byte address 0.
- R2: For every instruction other than a taken branch or a jump, the next program counter is the current one plus 4.
- R3: An instruction word is split into opcode [31:26], rs [25:21], rt [20:16] and rd [15:11], with funct in [5:0]. With opcode 0x00 and funct 0x20, the core writes rs+rt into rd. With funct 0x22, it writes rs-rt into rd. Both results wrap modulo 2^32.
- R4: Opcode 0x0D ORs rs with the zero-extended 16-bit immediate [15:0] and writes the result into rt.
- R5: Opcode 0x23 loads the data word at byte address rs + sign-extended immediate into rt. Opcode 0x2B stores rt at that address and writes no register. A stored word is returned by a later load of the same address.
- R6: Opcode 0x04 compares rs and rt. When they are equal, the next counter is PC+4 plus the sign-extended immediate shifted left by 2, and backward offsets are allowed. Otherwise the next counter is PC+4. The instruction writes no register.
- R7: Opcode 0x02 sets the counter to {PC+4[31:28], target[25:0], 2'b00} and writes no register.
- R8: Register 0 always reads as zero. An instruction whose destination is register 0 commits nothing, and dbg_wr_en stays low.
- R9: Any other opcode, and any opcode 0x00 word whose funct is neither 0x20 nor 0x22, writes no register and no data word, and advances the counter by 4.
- R10: dbg_wr_en, dbg_wr_reg and dbg_wr_data describe the register write of the instruction at dbg_pc. That write takes effect at the next rising edge of clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| ld_imem_we | input | 1 | Write ld_data into the instruction store at word ld_addr |
| ld_dmem_we | input | 1 | Write ld_data into the data store at word ld_addr |
| ld_addr | input | LD_AW | Word address for the load port |
| ld_data | input | 32 | Word written by the load port |
| dbg_pc | output | 32 | Byte address of the instruction executing this cycle |
| dbg_wr_en | output | 1 | The current instruction writes a register at the next edge |
| dbg_wr_reg | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value of that write |

## Verification
The data store is reachable from the ports only through loads. A store can therefore be seen only by loading a word at the same address afterwards and watching the write-back on the debug port. The store stimulus overwrites a preloaded word using a negative displacement, then reads it back with a different base. The backward taken branch is built the same way: a loop-closing compare of register 0 with itself returns the program to address 0. A decoder fault that treats an unknown opcode as a store is exposed by an unlisted store-like opcode that targets a preloaded word. A later load then shows that word unchanged.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int XLEN  = 32;
  localparam int NREGS = 32;
  localparam int RIDX  = $clog2(NREGS);

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] FN_ADD    = 6'h20;
  localparam logic [5:0] FN_SUB    = 6'h22;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;
    logic    src_imm;
    logic    load_wb;
    logic    reg_we;
    logic    mem_we;
    logic    branch;
    logic    jump;
    logic    ext_sign;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/scp_ctrl.sv
module scp_ctrl
  import scp_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    unique case (opcode)
      OPC_RTYPE: begin
        if (funct == FN_ADD) begin
          ctl.dst_rd = 1'b1;
          ctl.reg_we = 1'b1;
        end else if (funct == FN_SUB) begin
          ctl.dst_rd = 1'b1;
          ctl.reg_we = 1'b1;
          ctl.alu_op = ALU_SUB;
        end
      end
      OPC_ORI: begin
        ctl.src_imm = 1'b1;
        ctl.reg_we  = 1'b1;
        ctl.alu_op  = ALU_OR;
      end
      OPC_LW: begin
        ctl.src_imm  = 1'b1;
        ctl.ext_sign = 1'b1;
        ctl.load_wb  = 1'b1;
        ctl.reg_we   = 1'b1;
      end
      OPC_SW: begin
        ctl.src_imm  = 1'b1;
        ctl.ext_sign = 1'b1;
        ctl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      OPC_JUMP: ctl.jump = 1'b1;
      default: ;
    endcase
  end

  // R9: at most one architectural effect per decoded word
  always_comb begin
    assert_one_effect_R9: assert ($onehot0({ctl.reg_we, ctl.mem_we, ctl.branch, ctl.jump}));
    // R5: a store never also writes back
    assert_store_no_wb_R5: assert (!(ctl.mem_we && ctl.load_wb));
  end

endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            eq
);

  logic [XLEN-1:0] diff;

  always_comb begin
    diff = a - b;
    eq   = (diff == '0);
    unique case (op)
      ALU_SUB: y = diff;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
  import scp_pkg::*;
(
  input  logic            clk,
  input  logic            we,
  input  logic [RIDX-1:0] wa,
  input  logic [XLEN-1:0] wd,
  input  logic [RIDX-1:0] ra1,
  input  logic [RIDX-1:0] ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2
);

  logic [XLEN-1:0] regs_q [NREGS];
  logic            wr_en;

  always_comb wr_en = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (wr_en) regs_q[wa] <= wd;
  end

  always_comb begin
    rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
  end

endmodule

// File: rtl/scp_wordmem.sv
module scp_wordmem #(
  parameter  int WIDTH = 32,
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  always_comb rdata = mem_q[raddr];

endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter  int IMEM_WORDS = 64,
  parameter  int DMEM_WORDS = 64,
  localparam int IAW        = $clog2(IMEM_WORDS),
  localparam int DAW        = $clog2(DMEM_WORDS),
  localparam int LD_AW      = (IAW > DAW) ? IAW : DAW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_imem_we,
  input  logic             ld_dmem_we,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]  ld_data,
  output logic [XLEN-1:0]  dbg_pc,
  output logic             dbg_wr_en,
  output logic [RIDX-1:0]  dbg_wr_reg,
  output logic [XLEN-1:0]  dbg_wr_data
);

  // reset release synchronizer
  logic [1:0] rst_sync_q, rst_sync_d;
  logic       run;

  always_comb rst_sync_d = {rst_sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= rst_sync_d;
  end

  always_comb run = rst_sync_q[1];

  // program counter
  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_off;

  always_ff @(posedge clk or negedge run) begin
    if (!run) pc_q <= '0;
    else      pc_q <= pc_d;
  end

  // fetch
  logic [XLEN-1:0] instr;

  scp_wordmem #(.WIDTH(XLEN), .DEPTH(IMEM_WORDS)) u_imem (
    .clk   (clk),
    .we    (ld_imem_we),
    .waddr (ld_addr[IAW-1:0]),
    .wdata (ld_data),
    .raddr (pc_q[IAW+1:2]),
    .rdata (instr)
  );

  // decode
  logic [RIDX-1:0] f_rs, f_rt, f_rd;
  logic [15:0]     f_imm;
  ctrl_t           ctl;

  always_comb begin
    f_rs  = instr[25:21];
    f_rt  = instr[20:16];
    f_rd  = instr[15:11];
    f_imm = instr[15:0];
  end

  scp_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  // operands and execute
  logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data, dm_rdata;
  logic [RIDX-1:0] wb_reg;
  logic            alu_eq, rf_we;

  always_comb begin
    imm_ext = ctl.ext_sign ? {{(XLEN-16){f_imm[15]}}, f_imm} : {{(XLEN-16){1'b0}}, f_imm};
    alu_b   = ctl.src_imm ? imm_ext : rt_val;
  end

  scp_alu u_alu (
    .a  (rs_val),
    .b  (alu_b),
    .op (ctl.alu_op),
    .y  (alu_y),
    .eq (alu_eq)
  );

  // data store: load port has priority, core writes only while running
  logic           dm_we;
  logic [DAW-1:0] dm_waddr;
  logic [XLEN-1:0] dm_wdata;

  always_comb begin
    dm_we    = ld_dmem_we | (run & ctl.mem_we);
    dm_waddr = ld_dmem_we ? ld_addr[DAW-1:0] : alu_y[DAW+1:2];
    dm_wdata = ld_dmem_we ? ld_data : rt_val;
  end

  scp_wordmem #(.WIDTH(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[DAW+1:2]),
    .rdata (dm_rdata)
  );

  // write-back
  always_comb begin
    wb_reg  = ctl.dst_rd ? f_rd : f_rt;
    wb_data = ctl.load_wb ? dm_rdata : alu_y;
    rf_we   = run & ctl.reg_we & (wb_reg != '0);
  end

  scp_regfile u_rf (
    .clk (clk),
    .we  (rf_we),
    .wa  (wb_reg),
    .wd  (wb_data),
    .ra1 (f_rs),
    .ra2 (f_rt),
    .rd1 (rs_val),
    .rd2 (rt_val)
  );

  // next program counter
  always_comb begin
    pc_plus4 = pc_q + 32'd4;
    br_off   = {{(XLEN-18){f_imm[15]}}, f_imm, 2'b00};
    if (ctl.jump)                 pc_d = {pc_plus4[31:28], instr[25:0], 2'b00};
    else if (ctl.branch && alu_eq) pc_d = pc_plus4 + br_off;
    else                          pc_d = pc_plus4;
  end

  always_comb begin
    dbg_pc      = pc_q;
    dbg_wr_en   = rf_we;
    dbg_wr_reg  = wb_reg;
    dbg_wr_data = wb_data;
  end

  // R2: sequential flow advances by one word
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!run)
    (!ctl.branch && !ctl.jump) |=> (pc_q == $past(pc_q) + 32'd4));

  // R6: an unequal compare falls through
  assert_beq_fall_R6: assert property (@(posedge clk) disable iff (!run)
    (ctl.branch && (rs_val != rt_val)) |=> (pc_q == $past(pc_q) + 32'd4));

  // R7: jump lands on the word-aligned target field
  assert_jump_target_R7: assert property (@(posedge clk) disable iff (!run)
    ctl.jump |=> ((pc_q[27:2] == $past(instr[25:0])) && (pc_q[1:0] == 2'b00)));

  // R8: the debug port never reports a commit to register 0
  assert_no_r0_commit_R8: assert property (@(posedge clk) disable iff (!run)
    dbg_wr_en |-> (dbg_wr_reg != '0));

endmodule

// File: tb/test_scp_core.sv
module test_scp_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_imem_we = 1'b0;
  logic        ld_dmem_we = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_reg;
  logic [31:0] dbg_wr_data;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scp_core i_scp_core (
    .clk(clk), .rst_n(rst_n), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
    .dbg_wr_reg(dbg_wr_reg), .dbg_wr_data(dbg_wr_data)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic put_imem(int a, logic [31:0] w);
    ld_imem_we = 1'b1; ld_addr = a[5:0]; ld_data = w;
    @(negedge clk);
    ld_imem_we = 1'b0;
  endtask

  task automatic put_dmem(int a, logic [31:0] w);
    ld_dmem_we = 1'b1; ld_addr = a[5:0]; ld_data = w;
    @(negedge clk);
    ld_dmem_we = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  // check current instruction's debug view, then advance one cycle
  task automatic step(string req, logic [31:0] pc, logic we, int rg, logic [31:0] data);
    check(req, "pc", dbg_pc, pc);
    check("R10", "wr_en", {31'd0, dbg_wr_en}, {31'd0, we});
    if (we) begin
      check("R10", "wr_reg", {27'd0, dbg_wr_reg}, rg);
      check(req, "wr_data", dbg_wr_data, data);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    hold_reset();
    put_imem(0, enc_i(6'h0D, 0, 1, 16'h0005));
    check("R1", "pc in reset", dbg_pc, 32'd0);
    check("R1", "wr_en in reset", {31'd0, dbg_wr_en}, 32'd0);
    @(negedge clk);
    check("R1", "pc in reset later", dbg_pc, 32'd0);
    release_reset();
    step("R1", 32'd0, 1'b1, 1, 32'h5);
  endtask

  task automatic t_arith();
    hold_reset();
    put_imem(0, enc_i(6'h0D, 0, 1, 16'h8001));
    put_imem(1, enc_i(6'h0D, 0, 2, 16'hFFFF));
    put_imem(2, enc_r(1, 2, 3, 6'h20));
    put_imem(3, enc_r(1, 2, 4, 6'h22));
    put_imem(4, enc_i(6'h0D, 4, 5, 16'h00F0));
    put_imem(5, enc_r(3, 4, 6, 6'h20));
    release_reset();
    step("R4", 32'd0,  1'b1, 1, 32'h0000_8001);
    step("R4", 32'd4,  1'b1, 2, 32'h0000_FFFF);
    step("R3", 32'd8,  1'b1, 3, 32'h0001_8000);
    step("R3", 32'd12, 1'b1, 4, 32'hFFFF_8002);
    step("R4", 32'd16, 1'b1, 5, 32'hFFFF_80F2);
    step("R3", 32'd20, 1'b1, 6, 32'h0001_0002);
    check("R2", "pc after run", dbg_pc, 32'd24);
  endtask

  task automatic t_mem();
    hold_reset();
    put_dmem(2, 32'h1234_5678);
    put_dmem(3, 32'hCAFE_F00D);
    put_imem(0, enc_i(6'h0D, 0, 1, 16'd16));
    put_imem(1, enc_i(6'h23, 1, 2, 16'hFFFC));
    put_imem(2, enc_i(6'h2B, 1, 2, 16'hFFF8));
    put_imem(3, enc_i(6'h23, 0, 3, 16'h0008));
    release_reset();
    step("R5", 32'd0,  1'b1, 1, 32'd16);
    step("R5", 32'd4,  1'b1, 2, 32'hCAFE_F00D);
    step("R5", 32'd8,  1'b0, 0, 32'd0);
    step("R5", 32'd12, 1'b1, 3, 32'hCAFE_F00D);
  endtask

  task automatic t_branch();
    hold_reset();
    put_imem(0, enc_i(6'h0D, 0, 1, 16'd7));
    put_imem(1, enc_i(6'h0D, 0, 2, 16'd7));
    put_imem(2, enc_i(6'h04, 1, 2, 16'd2));
    put_imem(3, enc_i(6'h0D, 0, 9, 16'hDEAD));
    put_imem(4, enc_i(6'h0D, 0, 9, 16'hBEEF));
    put_imem(5, enc_i(6'h0D, 0, 3, 16'd9));
    put_imem(6, enc_i(6'h04, 1, 3, 16'd5));
    put_imem(7, enc_i(6'h04, 0, 0, 16'hFFF8));
    release_reset();
    step("R4", 32'd0,  1'b1, 1, 32'd7);
    step("R4", 32'd4,  1'b1, 2, 32'd7);
    step("R6", 32'd8,  1'b0, 0, 32'd0);
    step("R6", 32'd20, 1'b1, 3, 32'd9);
    step("R6", 32'd24, 1'b0, 0, 32'd0);
    step("R6", 32'd28, 1'b0, 0, 32'd0);
    step("R6", 32'd0,  1'b1, 1, 32'd7);
  endtask

  task automatic t_jump();
    hold_reset();
    put_imem(0, enc_j(26'd5));
    put_imem(1, enc_i(6'h0D, 0, 9, 16'hDEAD));
    put_imem(5, enc_i(6'h0D, 0, 1, 16'd1));
    put_imem(6, enc_j(26'd0));
    release_reset();
    step("R7", 32'd0,  1'b0, 0, 32'd0);
    step("R7", 32'd20, 1'b1, 1, 32'd1);
    step("R7", 32'd24, 1'b0, 0, 32'd0);
    step("R7", 32'd0,  1'b0, 0, 32'd0);
  endtask

  task automatic t_zero();
    hold_reset();
    put_imem(0, enc_i(6'h0D, 0, 0, 16'h0055));
    put_imem(1, enc_i(6'h0D, 0, 6, 16'h0000));
    put_imem(2, enc_i(6'h0D, 0, 1, 16'h0003));
    put_imem(3, enc_r(1, 1, 0, 6'h20));
    put_imem(4, enc_r(0, 0, 7, 6'h20));
    release_reset();
    step("R8", 32'd0,  1'b0, 0, 32'd0);
    step("R8", 32'd4,  1'b1, 6, 32'd0);
    step("R8", 32'd8,  1'b1, 1, 32'd3);
    step("R8", 32'd12, 1'b0, 0, 32'd0);
    step("R8", 32'd16, 1'b1, 7, 32'd0);
  endtask

  task automatic t_illegal();
    hold_reset();
    put_dmem(0, 32'h0000_0011);
    put_imem(0, enc_i(6'h0D, 0, 1, 16'd3));
    put_imem(1, enc_i(6'h3F, 1, 2, 16'h0004));
    put_imem(2, enc_r(1, 1, 2, 6'h24));
    put_imem(3, enc_i(6'h29, 0, 1, 16'h0000));
    put_imem(4, enc_i(6'h23, 0, 3, 16'h0000));
    release_reset();
    step("R9", 32'd0,  1'b1, 1, 32'd3);
    step("R9", 32'd4,  1'b0, 0, 32'd0);
    step("R9", 32'd8,  1'b0, 0, 32'd0);
    step("R9", 32'd12, 1'b0, 0, 32'd0);
    step("R9", 32'd16, 1'b1, 3, 32'h0000_0011);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_arith();
    t_mem();
    t_branch();
    t_jump();
    t_zero();
    t_illegal();
    finish_run();
  end

endmodule